// File: doc/BRIEF.md
# Pointer-Addressed Byte Store With Toggle Locks

This block holds a byte array of parameterised depth that a host reaches through a small window of four byte-wide ports. Two of the ports load the halves of a 16-bit pointer, one port moves data to or from the byte the pointer selects, and the remaining port does nothing. After every data write the pointer returns to zero. Reads leave the pointer alone, so the same byte can be read again without reloading it.

Two lock bits each guard one 16-byte window of the array: lock 0 covers 0x20 to 0x2F and lock 1 covers 0x30 to 0x3F. A separate toggle input, with a one-bit selector, flips the chosen lock bit. A guarded byte, like any address at or past the array depth, cannot be written, and reading it returns 0xFF. Read data is registered: it appears on the cycle after the read strobe and holds until the next read. The array contents survive reset.

Top module: `nvram_port`

## Requirements
- R1: A write to port 0 loads pointer bits 7:0 and a write to port 1 loads pointer bits 15:8. In both cases the other pointer byte is left unchanged.
- R2: A write to port 3 stores the data byte at the pointed address when that address is accessible. The pointer becomes 0x0000 after this write, whether or not the store happened.
- R3: A read of port 3 at an accessible address puts that byte on `rdata` on the next cycle. `rdata` holds its value on every cycle without a read strobe.
- R4: A read of port 0, 1 or 2 returns 0xFF.
- R5: While lock bit 0 is set, addresses 0x20 to 0x2F read as 0xFF and writes to them are dropped.
- R6: While lock bit 1 is set, addresses 0x30 to 0x3F read as 0xFF and writes to them are dropped.
- R7: A cycle with `lock_tgl` high inverts the lock bit chosen by `lock_sel` (0 selects lock 0, 1 selects lock 1). The other lock bit is not affected.
- R8: Reset clears both lock bits and the pointer and sets `rdata` to 0xFF. Array contents are kept through reset.
- R9: A write at an address at or beyond DEPTH changes no byte, including the byte its low address bits would alias to. A read there returns 0xFF.
- R10: A read does not change the pointer. When a read and a write happen in the same cycle, the read sees the pointer and contents from before that write.
- R11: A write to port 2 changes neither the pointer nor the array.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_off | input | 2 | Port select within the window (0 low pointer, 1 high pointer, 2 unused, 3 data) |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Registered read byte |
| lock_tgl | input | 1 | Invert the selected lock bit |
| lock_sel | input | 1 | Lock bit selector |

## Verification
The bench builds the block with DEPTH = 80. This places both locked windows inside the array and puts the end-of-array boundary at 0x50, where a few pointer loads can reach it. It also makes the array depth a value that is not a power of two, so an out-of-range pointer such as 0x0110 has low bits that alias onto a real byte (0x10). Checking that byte afterwards catches a range check that only looks at the low bits. Because the array is this small, the bench can fill every byte with a known pattern before it reads anything.

// File: rtl/nvp_pkg.sv
// Package: shared port codes and fixed lock layout for the pointer-addressed store.
// Assumes a four-port window decoded by a 2-bit offset.
package nvp_pkg;
    typedef enum logic [1:0] {
        PORT_PTR_LO = 2'd0,
        PORT_PTR_HI = 2'd1,
        PORT_SPARE  = 2'd2,
        PORT_DATA   = 2'd3
    } port_t;

    localparam int NUM_WINDOWS = 2;
    localparam logic [7:0] READ_BLANK = 8'hFF;
endpackage

// File: rtl/nvp_pointer.sv
// Module: 16-bit access pointer, loaded one byte at a time, cleared after a data write.
// Assumes load and clear are never asserted together (decoded from one offset).
module nvp_pointer #(
    parameter int PTR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_lo,
    input  logic             load_hi,
    input  logic             clear,
    input  logic [7:0]       byte_in,
    output logic [PTR_W-1:0] ptr
);
    // Pointer register: byte loads, clear on data write, zero on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       ptr <= '0;
        else if (clear)   ptr <= '0;
        else if (load_lo) ptr[7:0] <= byte_in;
        else if (load_hi) ptr[PTR_W-1:8] <= byte_in[PTR_W-9:0];
    end

    p_clear_after_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (ptr == '0));
    p_lo_keeps_hi_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (load_lo && !clear) |=> (ptr[PTR_W-1:8] == $past(ptr[PTR_W-1:8])));
    p_hi_keeps_lo_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (load_hi && !clear && !load_lo) |=> (ptr[7:0] == $past(ptr[7:0])));
    p_idle_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_lo && !load_hi && !clear) |=> $stable(ptr));
endmodule

// File: rtl/nvp_lock_guard.sv
// Module: toggle-controlled lock bits and the access-permission decode for one address.
// Assumes windows are contiguous, WIN_BYTES long each, starting at LOCK_BASE.
module nvp_lock_guard
    import nvp_pkg::*;
#(
    parameter int PTR_W     = 16,
    parameter int DEPTH     = 256,
    parameter int LOCK_BASE = 32,
    parameter int WIN_BYTES = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tgl,
    input  logic                   sel,
    input  logic [PTR_W-1:0]       addr,
    output logic [NUM_WINDOWS-1:0] lock_q,
    output logic                   allowed
);
    localparam logic [PTR_W-1:0] LIMIT = PTR_W'(DEPTH);

    logic [NUM_WINDOWS-1:0] hit;

    // Lock bits: each toggle command inverts the selected bit.
    always_ff @(posedge clk) begin
        if (!rst_n)   lock_q <= '0;
        else if (tgl) lock_q[sel] <= ~lock_q[sel];
    end

    // Per-window hit: address inside a window whose lock bit is set.
    for (genvar w = 0; w < NUM_WINDOWS; w++) begin : g_win
        localparam logic [PTR_W-1:0] LO = PTR_W'(LOCK_BASE + w * WIN_BYTES);
        localparam logic [PTR_W-1:0] HI = PTR_W'(LOCK_BASE + (w + 1) * WIN_BYTES);
        assign hit[w] = lock_q[w] && (addr >= LO) && (addr < HI);
    end

    // Permission: inside the array and not in a locked window.
    always_comb allowed = (addr < LIMIT) && (hit == '0);

    p_toggle_flips_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tgl |=> (lock_q[$past(sel)] != $past(lock_q[sel])));
    p_toggle_other_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tgl |=> (lock_q[~$past(sel)] == $past(lock_q[~sel])));
    p_lock_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !tgl |=> $stable(lock_q));
endmodule

// File: rtl/nvp_store.sv
// Module: byte array, one synchronous write port and one combinational read port.
// Assumes callers only use read data for in-range addresses; contents are not reset.
module nvp_store #(
    parameter int DEPTH = 256,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [7:0]       wdata,
    input  logic [IDX_W-1:0] raddr,
    output logic [7:0]       rdata
);
    logic [7:0] mem [DEPTH];

    // Array write: one byte per enabled cycle.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Array read: unregistered lookup, masked by the caller.
    always_comb rdata = mem[raddr];
endmodule

// File: rtl/nvram_port.sv
// Module: four-port window onto a byte array, with a pointer and two lockable windows.
// Assumes a host issues at most one write per cycle; the read is registered.
module nvram_port
    import nvp_pkg::*;
#(
    parameter int DEPTH     = 256,
    parameter int PTR_W     = 16,
    parameter int LOCK_BASE = 32,
    parameter int WIN_BYTES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] port_off,
    input  logic       rd_en,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       lock_tgl,
    input  logic       lock_sel
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam logic [PTR_W-1:0] LIMIT = PTR_W'(DEPTH);

    port_t                  port;
    logic [PTR_W-1:0]       ptr;
    logic [NUM_WINDOWS-1:0] lock_q;
    logic                   allowed;
    logic [7:0]             arr_byte;
    logic                   data_wr;

    // Offset decode into the named port codes.
    always_comb port = port_t'(port_off);
    always_comb data_wr = wr_en && (port == PORT_DATA);

    nvp_pointer #(.PTR_W(PTR_W)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_lo (wr_en && (port == PORT_PTR_LO)),
        .load_hi (wr_en && (port == PORT_PTR_HI)),
        .clear   (data_wr),
        .byte_in (wdata),
        .ptr     (ptr)
    );

    nvp_lock_guard #(
        .PTR_W(PTR_W), .DEPTH(DEPTH), .LOCK_BASE(LOCK_BASE), .WIN_BYTES(WIN_BYTES)
    ) u_guard (
        .clk     (clk),
        .rst_n   (rst_n),
        .tgl     (lock_tgl),
        .sel     (lock_sel),
        .addr    (ptr),
        .lock_q  (lock_q),
        .allowed (allowed)
    );

    nvp_store #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
        .clk   (clk),
        .we    (data_wr && allowed),
        .waddr (ptr[IDX_W-1:0]),
        .wdata (wdata),
        .raddr (ptr[IDX_W-1:0]),
        .rdata (arr_byte)
    );

    // Read register: data byte when permitted, blank otherwise, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= READ_BLANK;
        else if (rd_en) rdata <= (port == PORT_DATA && allowed) ? arr_byte : READ_BLANK;
    end

    p_read_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));
    p_non_data_read_ones_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && port != PORT_DATA) |=> (rdata == READ_BLANK));
    p_win0_read_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && lock_q[0] && ptr[PTR_W-1:4] == PTR_W'(LOCK_BASE) >> 4) |=> (rdata == READ_BLANK));
    p_win1_read_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && lock_q[1] && ptr[PTR_W-1:4] == PTR_W'(LOCK_BASE + WIN_BYTES) >> 4) |=> (rdata == READ_BLANK));
    p_range_read_ones_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && ptr >= LIMIT) |=> (rdata == READ_BLANK));
    p_reset_clears_r8: assert property (@(posedge clk)
        !rst_n |=> (lock_q == '0 && ptr == '0 && rdata == READ_BLANK));
endmodule

// File: tb/nvram_port_tb_top.sv
// Bench: behavioural model of pointer, locks, array and read register, compared every cycle.
module nvram_port_tb_top;
    localparam int DEPTH = 80;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] port_off = 2'd0;
    logic       rd_en = 1'b0, wr_en = 1'b0, lock_tgl = 1'b0, lock_sel = 1'b0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;

    int checks = 0;
    int errors = 0;

    logic [7:0]  m_mem [DEPTH];
    logic [15:0] m_ptr = 16'd0;
    logic [1:0]  m_lock = 2'b00;
    logic [7:0]  m_rdata = 8'hFF;

    always #5 clk = ~clk;

    nvram_port #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .port_off(port_off), .rd_en(rd_en), .wr_en(wr_en),
        .wdata(wdata), .rdata(rdata), .lock_tgl(lock_tgl), .lock_sel(lock_sel)
    );

    function automatic bit ok(input logic [15:0] a);
        if (int'(a) >= DEPTH) return 1'b0;
        if (m_lock[0] && a >= 16'h20 && a <= 16'h2F) return 1'b0;
        if (m_lock[1] && a >= 16'h30 && a <= 16'h3F) return 1'b0;
        return 1'b1;
    endfunction

    task automatic check(input string tag);
        checks++;
        if (rdata !== m_rdata) begin
            errors++;
            $display("FAIL %s: rdata=%02h expected=%02h", tag, rdata, m_rdata);
        end
    endtask

    // One cycle: drive at negedge, model at posedge, compare at the next negedge.
    task automatic step(input logic [1:0] off, input logic rd, input logic wr,
                        input logic [7:0] d, input logic tg, input logic sel,
                        input string tag);
        port_off = off; rd_en = rd; wr_en = wr; wdata = d; lock_tgl = tg; lock_sel = sel;
        @(posedge clk);
        if (rd) m_rdata = (off == 2'd3 && ok(m_ptr)) ? m_mem[m_ptr[6:0]] : 8'hFF;
        if (wr) begin
            case (off)
                2'd0: m_ptr[7:0] = d;
                2'd1: m_ptr[15:8] = d;
                2'd3: begin
                    if (ok(m_ptr)) m_mem[m_ptr[6:0]] = d;
                    m_ptr = 16'd0;
                end
                default: ;
            endcase
        end
        if (tg) m_lock[sel] = ~m_lock[sel];
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0; lock_tgl = 1'b0;
        check(tag);
    endtask

    task automatic set_ptr(input logic [15:0] a, input string tag);
        step(2'd0, 1'b0, 1'b1, a[7:0], 1'b0, 1'b0, tag);
        step(2'd1, 1'b0, 1'b1, a[15:8], 1'b0, 1'b0, tag);
    endtask

    task automatic poke(input logic [15:0] a, input logic [7:0] d, input string tag);
        set_ptr(a, tag);
        step(2'd3, 1'b0, 1'b1, d, 1'b0, 1'b0, tag);
    endtask

    task automatic peek(input logic [15:0] a, input string tag);
        set_ptr(a, tag);
        step(2'd3, 1'b1, 1'b0, 8'd0, 1'b0, 1'b0, tag);
    endtask

    task automatic do_reset(input string tag);
        rst_n = 1'b0;
        @(posedge clk); @(posedge clk);
        m_ptr = 16'd0; m_lock = 2'b00; m_rdata = 8'hFF;
        @(negedge clk);
        rst_n = 1'b1;
        check(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset("R8");
        // Fill every byte with a known pattern.
        for (int a = 0; a < DEPTH; a++) poke(16'(a), 8'(a) ^ 8'h5A, "R2");
        for (int a = 0; a < DEPTH; a += 7) peek(16'(a), "R3");
        // Repeated reads at one pointer.
        step(2'd3, 1'b1, 1'b0, 8'd0, 1'b0, 1'b0, "R10");
        step(2'd3, 1'b1, 1'b0, 8'd0, 1'b0, 1'b0, "R10");
        step(2'd3, 1'b0, 1'b0, 8'd0, 1'b0, 1'b0, "R3");
        // Byte loads keep the other pointer byte.
        set_ptr(16'h0012, "R1");
        step(2'd1, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, "R1");
        step(2'd0, 1'b0, 1'b1, 8'h31, 1'b0, 1'b0, "R1");
        step(2'd3, 1'b1, 1'b0, 8'd0, 1'b0, 1'b0, "R1");
        step(2'd1, 1'b0, 1'b1, 8'h01, 1'b0, 1'b0, "R1");
        step(2'd1, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, "R1");
        step(2'd3, 1'b1, 1'b0, 8'd0, 1'b0, 1'b0, "R1");
        // Non-data ports read blank.
        step(2'd0, 1'b1, 1'b0, 8'd0, 1'b0, 1'b0, "R4");
        step(2'd1, 1'b1, 1'b0, 8'd0, 1'b0, 1'b0, "R4");
        step(2'd2, 1'b1, 1'b0, 8'd0, 1'b0, 1'b0, "R4");
        // Spare port write ignored.
        set_ptr(16'h0005, "R11");
        step(2'd2, 1'b0, 1'b1, 8'hC3, 1'b0, 1'b0, "R11");
        step(2'd3, 1'b1, 1'b0, 8'd0, 1'b0, 1'b0, "R11");
        // Data write clears pointer: next read is at 0.
        poke(16'h0044, 8'h99, "R2");
        step(2'd3, 1'b1, 1'b0, 8'd0, 1'b0, 1'b0, "R2");
        peek(16'h0044, "R2");
        // Lock 0.
        step(2'd0, 1'b0, 1'b0, 8'd0, 1'b1, 1'b0, "R7");
        peek(16'h0025, "R5");
        peek(16'h002F, "R5");
        peek(16'h0030, "R5");
        peek(16'h001F, "R5");
        poke(16'h0025, 8'hE1, "R5");
        step(2'd3, 1'b1, 1'b0, 8'd0, 1'b0, 1'b0, "R2");
        step(2'd0, 1'b0, 1'b0, 8'd0, 1'b1, 1'b0, "R7");
        peek(16'h0025, "R5");
        // Lock 1.
        step(2'd0, 1'b0, 1'b0, 8'd0, 1'b1, 1'b1, "R7");
        peek(16'h0030, "R6");
        peek(16'h003F, "R6");
        peek(16'h0040, "R6");
        peek(16'h0020, "R6");
        poke(16'h003A, 8'h7E, "R6");
        step(2'd0, 1'b0, 1'b0, 8'd0, 1'b1, 1'b1, "R7");
        peek(16'h003A, "R6");
        // Out of range.
        poke(16'h0050, 8'h11, "R9");
        peek(16'h0050, "R9");
        peek(16'h004F, "R9");
        poke(16'h0110, 8'h22, "R9");
        peek(16'h0110, "R9");
        peek(16'h0010, "R9");
        peek(16'hFFFF, "R9");
        // Read and write in the same cycle.
        set_ptr(16'h0033, "R10");
        step(2'd3, 1'b1, 1'b1, 8'h6D, 1'b0, 1'b0, "R10");
        peek(16'h0033, "R10");
        // Reset clears locks but keeps contents.
        step(2'd0, 1'b0, 1'b0, 8'd0, 1'b1, 1'b0, "R7");
        step(2'd0, 1'b0, 1'b0, 8'd0, 1'b1, 1'b1, "R7");
        peek(16'h0021, "R7");
        set_ptr(16'h0033, "R8");
        do_reset("R8");
        step(2'd3, 1'b1, 1'b0, 8'd0, 1'b0, 1'b0, "R8");
        peek(16'h0021, "R8");
        peek(16'h0033, "R8");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule